// File: doc/BRIEF.md
# Channel Attention Command Decoder

The block interprets the 16-bit control word that a host leaves in a shared control area each time it raises a channel-attention strobe. One word carries two independent unit-control fields, one for the command unit and one for the receive unit. It also carries four write-one acknowledge bits for sticky event flags and a soft-reset request. The decoder updates the two unit state registers and clears the acknowledged events. It then asks the memory side to overwrite the word with zero and publishes a status word built from the event flags and both unit states.

Strobes can arrive faster than the decoder finishes a word. Every strobe is counted, and the pending strobes are served one at a time until none remain. The command and receive units report their events through one-cycle set pulses. An interrupt pulse follows any status write-back that shows a completion or a received frame.

Top module: `attn_cmd_decoder`

## Requirements
- R1: Command-unit code (word bits 10:8): 1 sets the command-unit state to active (2); 4 sets it to suspended (1) and raises the command-unit-left-active event (status bit 13); 0 leaves the state unchanged.
- R2: Receive-unit code (word bits 6:4): 1 or 2 sets the receive-unit state to ready (0); 3 or 4 sets it to suspended (1) and raises the receive-unit-left-active event (status bit 12); 0 leaves it unchanged.
- R3: Word bits 15:12 each clear the matching sticky event (15 completion-with-interrupt, 14 frame received, 13 command unit left active, 12 receive unit left active). The clear is applied before any event raised by the same word, so an abort that also acknowledges its own event leaves that event set.
- R4: Word bit 7 performs a soft reset that overrides both codes: command unit idle (0), receive unit suspended (1), all four events cleared, and `soft_rst_o` pulses for one cycle.
- R5: The status word holds the events in bits 15:12, the command-unit state in bits 11:8, the receive-unit state in bits 7:4, and zero in bits 3:0.
- R6: One cycle after a word is accepted, `cmd_clr_o` pulses to request a zero write over the word. The status write strobe `status_wr_o` follows in the next cycle.
- R7: Each attention strobe causes exactly one service (one fetch, one clear, one status write). Strobes that arrive during a service, or back to back, are served in turn, and no service happens once the count is zero. `cmd_fetch_o` stays high until `cmd_valid_i` is seen.
- R8: A command-unit code other than 0, 1 or 4, or a receive-unit code above 4, leaves that unit's state unchanged and pulses `err_o` in the cycle after the word is accepted.
- R9: `irq_o` pulses for one cycle right after a status write whose word had bit 15 or bit 14 set, and stays low after any other write.
- R10: A set pulse on `cx_set_i`, `fr_set_i`, `cna_set_i` or `rnr_set_i` sets status bit 15, 14, 13 or 12 on the next edge. A set pulse wins over an acknowledge in the same cycle.
- R11: After hard reset the command unit is idle (0), the receive unit is suspended (1), the events are clear, the status word reads 0x0010, and no fetch, clear, write, error or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_i | input | 1 | Channel-attention strobe, one count per cycle high |
| cmd_fetch_o | output | 1 | Request for the control word |
| cmd_valid_i | input | 1 | Control word present on `cmd_word_i` |
| cmd_word_i | input | 16 | Control word from the shared area |
| cmd_clr_o | output | 1 | Request to write zero over the control word |
| cx_set_i | input | 1 | Command completed with interrupt request |
| fr_set_i | input | 1 | Frame received |
| cna_set_i | input | 1 | Command unit left active state |
| rnr_set_i | input | 1 | Receive unit left active state |
| status_o | output | 16 | Composed status word |
| status_wr_o | output | 1 | Status write-back strobe |
| cu_state_o | output | 4 | Command-unit state |
| ru_state_o | output | 4 | Receive-unit state |
| soft_rst_o | output | 1 | Soft reset pulse |
| err_o | output | 1 | Unknown control code pulse |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach is a pile-up of attention strobes. The bench raises the strobe in three consecutive cycles before the first word is served. It then confirms that exactly three fetch, clear and write rounds follow and that the fetch line stays quiet afterwards. A second hard case is one word that both raises an event and acknowledges it. The bench sends an abort that acknowledges its own event and checks that the event survives.

// File: rtl/attn_pkg.sv
package attn_pkg;

    localparam int CMD_W  = 16;
    localparam int CODE_W = 3;
    localparam int ST_W   = 4;

    typedef enum logic [ST_W-1:0] {
        CU_IDLE   = 4'd0,
        CU_SUSP   = 4'd1,
        CU_ACTIVE = 4'd2
    } cu_state_e;

    typedef enum logic [ST_W-1:0] {
        RU_READY = 4'd0,
        RU_SUSP  = 4'd1
    } ru_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_CLEAR,
        SQ_WRITE
    } seq_e;

    // sticky events, msb first matches status bits 15..12
    typedef struct packed {
        logic cx;
        logic fr;
        logic cna;
        logic rnr;
    } evt_t;

    typedef struct packed {
        evt_t              ack;
        logic [CODE_W-1:0] cu_code;
        logic [CODE_W-1:0] ru_code;
        logic              soft_rst;
    } cmd_fields_t;

    typedef struct packed {
        logic      known;
        logic      change;
        cu_state_e nxt;
        logic      evt;
    } cu_act_t;

    typedef struct packed {
        logic      known;
        logic      change;
        ru_state_e nxt;
        logic      evt;
    } ru_act_t;

    function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] w);
        cmd_fields_t f;
        f.ack      = evt_t'(w[15:12]);
        f.cu_code  = w[10:8];
        f.ru_code  = w[6:4];
        f.soft_rst = w[7];
        return f;
    endfunction

    function automatic cu_act_t decode_cu(input logic [CODE_W-1:0] c);
        cu_act_t a;
        a = '{known: 1'b0, change: 1'b0, nxt: CU_IDLE, evt: 1'b0};
        case (c)
            3'd0: a.known = 1'b1;
            3'd1: a = '{known: 1'b1, change: 1'b1, nxt: CU_ACTIVE, evt: 1'b0};
            3'd4: a = '{known: 1'b1, change: 1'b1, nxt: CU_SUSP, evt: 1'b1};
            default: a.known = 1'b0;
        endcase
        return a;
    endfunction

    function automatic ru_act_t decode_ru(input logic [CODE_W-1:0] c);
        ru_act_t a;
        a = '{known: 1'b0, change: 1'b0, nxt: RU_READY, evt: 1'b0};
        case (c)
            3'd0:       a.known = 1'b1;
            3'd1, 3'd2: a = '{known: 1'b1, change: 1'b1, nxt: RU_READY, evt: 1'b0};
            3'd3, 3'd4: a = '{known: 1'b1, change: 1'b1, nxt: RU_SUSP, evt: 1'b1};
            default:    a.known = 1'b0;
        endcase
        return a;
    endfunction

    function automatic logic [CMD_W-1:0] compose_status(input evt_t e,
                                                         input cu_state_e c,
                                                         input ru_state_e r);
        return {e, c, r, 4'h0};
    endfunction

endpackage

// File: rtl/attn_pend_cnt.sv
module attn_pend_cnt #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc_i,
    input  logic dec_i,
    output logic pend_o
);
    localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] CNT_ONE = {{(PEND_W-1){1'b0}}, 1'b1};

    logic [PEND_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
        end else if (dec_i && !inc_i) begin
            if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign pend_o = (cnt_q != '0);
endmodule

// File: rtl/attn_seq.sv
module attn_seq
    import attn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pend_i,
    input  logic valid_i,
    input  logic irq_req_i,
    output logic fetch_o,
    output logic accept_o,
    output logic clr_o,
    output logic wr_o,
    output logic irq_o
);
    seq_e st_q, st_n;
    logic irq_q;

    always_comb begin
        st_n = st_q;
        case (st_q)
            SQ_IDLE:  if (pend_i) st_n = SQ_FETCH;
            SQ_FETCH: if (valid_i) st_n = SQ_CLEAR;
            SQ_CLEAR: st_n = SQ_WRITE;
            SQ_WRITE: st_n = SQ_IDLE;
            default:  st_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            irq_q <= (st_q == SQ_WRITE) && irq_req_i;
        end
    end

    assign fetch_o  = (st_q == SQ_FETCH);
    assign accept_o = fetch_o && valid_i;
    assign clr_o    = (st_q == SQ_CLEAR);
    assign wr_o     = (st_q == SQ_WRITE);
    assign irq_o    = irq_q;
endmodule

// File: rtl/attn_unit_regs.sv
module attn_unit_regs
    import attn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic [CMD_W-1:0] word_i,
    input  evt_t             set_i,
    output cu_state_e        cu_o,
    output ru_state_e        ru_o,
    output evt_t             evt_o,
    output logic             srst_o,
    output logic             err_o
);
    cmd_fields_t f;
    cu_act_t     ca;
    ru_act_t     ra;
    cu_state_e   cu_q, cu_n;
    ru_state_e   ru_q, ru_n;
    evt_t        ev_q, ev_n, ack;
    logic        srst_q, err_q;

    always_comb begin
        f   = split_cmd(word_i);
        ca  = decode_cu(f.cu_code);
        ra  = decode_ru(f.ru_code);
        ack = upd_i ? f.ack : evt_t'(4'h0);
        cu_n = cu_q;
        ru_n = ru_q;
        // acknowledge first, then events raised by this word, then unit pulses
        ev_n = ev_q & ~ack;
        if (upd_i) begin
            if (ca.known && ca.change) begin
                cu_n = ca.nxt;
                if (ca.evt) ev_n.cna = 1'b1;
            end
            if (ra.known && ra.change) begin
                ru_n = ra.nxt;
                if (ra.evt) ev_n.rnr = 1'b1;
            end
        end
        ev_n = ev_n | set_i;
        if (upd_i && f.soft_rst) begin
            cu_n = CU_IDLE;
            ru_n = RU_SUSP;
            ev_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cu_q   <= CU_IDLE;
            ru_q   <= RU_SUSP;
            ev_q   <= '0;
            srst_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cu_q   <= cu_n;
            ru_q   <= ru_n;
            ev_q   <= ev_n;
            srst_q <= upd_i && f.soft_rst;
            err_q  <= upd_i && !(ca.known && ra.known);
        end
    end

    assign cu_o   = cu_q;
    assign ru_o   = ru_q;
    assign evt_o  = ev_q;
    assign srst_o = srst_q;
    assign err_o  = err_q;
endmodule

// File: rtl/attn_cmd_decoder.sv
module attn_cmd_decoder
    import attn_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        attn_i,
    output logic        cmd_fetch_o,
    input  logic        cmd_valid_i,
    input  logic [15:0] cmd_word_i,
    output logic        cmd_clr_o,
    input  logic        cx_set_i,
    input  logic        fr_set_i,
    input  logic        cna_set_i,
    input  logic        rnr_set_i,
    output logic [15:0] status_o,
    output logic        status_wr_o,
    output logic [3:0]  cu_state_o,
    output logic [3:0]  ru_state_o,
    output logic        soft_rst_o,
    output logic        err_o,
    output logic        irq_o
);
    logic      pend, accept;
    evt_t      evt, set_v;
    cu_state_e cu;
    ru_state_e ru;

    assign set_v = '{cx: cx_set_i, fr: fr_set_i, cna: cna_set_i, rnr: rnr_set_i};

    attn_pend_cnt #(.PEND_W(PEND_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (attn_i),
        .dec_i  (status_wr_o),
        .pend_o (pend)
    );

    attn_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .pend_i    (pend),
        .valid_i   (cmd_valid_i),
        .irq_req_i (evt.cx | evt.fr),
        .fetch_o   (cmd_fetch_o),
        .accept_o  (accept),
        .clr_o     (cmd_clr_o),
        .wr_o      (status_wr_o),
        .irq_o     (irq_o)
    );

    attn_unit_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .upd_i  (accept),
        .word_i (cmd_word_i),
        .set_i  (set_v),
        .cu_o   (cu),
        .ru_o   (ru),
        .evt_o  (evt),
        .srst_o (soft_rst_o),
        .err_o  (err_o)
    );

    assign status_o   = compose_status(evt, cu, ru);
    assign cu_state_o = cu;
    assign ru_state_o = ru;
endmodule

// File: rtl/attn_chk.sv
module attn_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_fetch_o,
    input logic        cmd_valid_i,
    input logic [15:0] cmd_word_i,
    input logic        cmd_clr_o,
    input logic        cx_set_i,
    input logic        fr_set_i,
    input logic [15:0] status_o,
    input logic        status_wr_o,
    input logic [3:0]  cu_state_o,
    input logic [3:0]  ru_state_o,
    input logic        soft_rst_o,
    input logic        err_o,
    input logic        irq_o
);
    logic acc;
    assign acc = cmd_fetch_o && cmd_valid_i;

    // R1
    cu_start_chk: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_word_i[10:8] == 3'd1 && !cmd_word_i[7] |=> cu_state_o == 4'd2);
    // R1
    cu_abort_chk: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_word_i[10:8] == 3'd4 && !cmd_word_i[7] |=> cu_state_o == 4'd1 && status_o[13]);
    // R2
    ru_susp_chk: assert property (@(posedge clk) disable iff (rst)
        acc && (cmd_word_i[6:4] == 3'd3 || cmd_word_i[6:4] == 3'd4) && !cmd_word_i[7]
        |=> ru_state_o == 4'd1 && status_o[12]);
    // R3
    ack_fr_chk: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_word_i[14] && !cmd_word_i[7] && !fr_set_i |=> !status_o[14]);
    // R4
    soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_word_i[7] |=> cu_state_o == 4'd0 && ru_state_o == 4'd1
        && status_o[15:12] == 4'd0 && soft_rst_o);
    // R6
    clr_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_clr_o |=> status_wr_o && !cmd_clr_o);
    // R7
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_fetch_o && !cmd_valid_i |=> cmd_fetch_o);
    // R8
    bad_cu_chk: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_word_i[10:8] == 3'd3 && !cmd_word_i[7] |=> err_o && $stable(cu_state_o));
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(status_wr_o) && ($past(status_o[15]) || $past(status_o[14])));
    // R10
    cx_set_chk: assert property (@(posedge clk) disable iff (rst)
        cx_set_i && !(acc && cmd_word_i[7]) |=> status_o[15]);
endmodule

bind attn_cmd_decoder attn_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_fetch_o (cmd_fetch_o),
    .cmd_valid_i (cmd_valid_i),
    .cmd_word_i  (cmd_word_i),
    .cmd_clr_o   (cmd_clr_o),
    .cx_set_i    (cx_set_i),
    .fr_set_i    (fr_set_i),
    .status_o    (status_o),
    .status_wr_o (status_wr_o),
    .cu_state_o  (cu_state_o),
    .ru_state_o  (ru_state_o),
    .soft_rst_o  (soft_rst_o),
    .err_o       (err_o),
    .irq_o       (irq_o)
);

// File: tb/sim_attn_cmd_decoder.sv
module sim_attn_cmd_decoder;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        attn_i = 1'b0;
    logic        cmd_fetch_o;
    logic        cmd_valid_i = 1'b0;
    logic [15:0] cmd_word_i = 16'h0;
    logic        cmd_clr_o;
    logic        cx_set_i = 1'b0, fr_set_i = 1'b0, cna_set_i = 1'b0, rnr_set_i = 1'b0;
    logic [15:0] status_o;
    logic        status_wr_o;
    logic [3:0]  cu_state_o, ru_state_o;
    logic        soft_rst_o, err_o, irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    attn_cmd_decoder u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_attn();
        @(negedge clk) attn_i = 1'b1;
        @(negedge clk) attn_i = 1'b0;
    endtask

    task automatic pulse_evt(input logic [3:0] e);
        @(negedge clk) {cx_set_i, fr_set_i, cna_set_i, rnr_set_i} = e;
        @(negedge clk) {cx_set_i, fr_set_i, cna_set_i, rnr_set_i} = 4'h0;
    endtask

    // serve one word; starts and ends on a falling edge
    task automatic serve(input logic [15:0] w, input logic [3:0] ecu, input logic [3:0] eru,
                         input bit eerr, input logic [15:0] estat, input bit eirq, input string tag);
        int n = 0;
        while (!cmd_fetch_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(cmd_fetch_o, {tag, " R7 fetch"}, 16'(cmd_fetch_o), 16'h1);
        cmd_valid_i = 1'b1;
        cmd_word_i  = w;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cmd_word_i  = 16'h0;
        chk(cmd_clr_o, {tag, " R6 clear"}, 16'(cmd_clr_o), 16'h1);
        chk(cu_state_o == ecu, {tag, " R1 cu"}, 16'(cu_state_o), 16'(ecu));
        chk(ru_state_o == eru, {tag, " R2 ru"}, 16'(ru_state_o), 16'(eru));
        chk(err_o == eerr, {tag, " R8 err"}, 16'(err_o), 16'(eerr));
        chk(soft_rst_o == w[7], {tag, " R4 soft reset"}, 16'(soft_rst_o), 16'(w[7]));
        @(negedge clk);
        chk(status_wr_o, {tag, " R6 write"}, 16'(status_wr_o), 16'h1);
        chk(status_o == estat, {tag, " R5 status"}, status_o, estat);
        @(negedge clk);
        chk(irq_o == eirq, {tag, " R9 irq"}, 16'(irq_o), 16'(eirq));
    endtask

    task automatic t_reset();
        chk(cu_state_o == 4'd0 && ru_state_o == 4'd1, "R11 unit states", {cu_state_o, ru_state_o}, 8'h01);
        chk(status_o == 16'h0010, "R11 status", status_o, 16'h0010);
        chk(!cmd_fetch_o && !cmd_clr_o && !status_wr_o && !err_o && !irq_o, "R11 strobes",
            {cmd_fetch_o, cmd_clr_o, status_wr_o, err_o, irq_o}, 16'h0);
    endtask

    task automatic t_start();
        pulse_attn();
        serve(16'h0100, 4'd2, 4'd1, 1'b0, 16'h0210, 1'b0, "R1 cu start");
        pulse_attn();
        serve(16'h0010, 4'd2, 4'd0, 1'b0, 16'h0200, 1'b0, "R2 ru start");
        pulse_attn();
        serve(16'h0020, 4'd2, 4'd0, 1'b0, 16'h0200, 1'b0, "R2 ru resume");
    endtask

    task automatic t_events();
        pulse_evt(4'b1100);
        chk(status_o == 16'hC200, "R10 event set", status_o, 16'hC200);
        pulse_attn();
        serve(16'h0000, 4'd2, 4'd0, 1'b0, 16'hC200, 1'b1, "R9 irq on events");
        pulse_attn();
        serve(16'h8000, 4'd2, 4'd0, 1'b0, 16'h4200, 1'b1, "R3 ack cx");
        pulse_attn();
        serve(16'h4000, 4'd2, 4'd0, 1'b0, 16'h0200, 1'b0, "R3 ack fr");
    endtask

    task automatic t_abort();
        pulse_attn();
        serve(16'h0400, 4'd1, 4'd0, 1'b0, 16'h2100, 1'b0, "R1 cu abort");
        pulse_attn();
        serve(16'h2400, 4'd1, 4'd0, 1'b0, 16'h2100, 1'b0, "R3 abort with own ack");
        pulse_attn();
        serve(16'h2000, 4'd1, 4'd0, 1'b0, 16'h0100, 1'b0, "R3 ack cna");
        pulse_attn();
        serve(16'h0030, 4'd1, 4'd1, 1'b0, 16'h1110, 1'b0, "R2 ru suspend");
        pulse_attn();
        serve(16'h1020, 4'd1, 4'd0, 1'b0, 16'h0100, 1'b0, "R2 ru resume with ack");
        pulse_attn();
        serve(16'h0040, 4'd1, 4'd1, 1'b0, 16'h1110, 1'b0, "R2 ru abort");
        pulse_attn();
        serve(16'h1000, 4'd1, 4'd1, 1'b0, 16'h0110, 1'b0, "R3 ack rnr");
    endtask

    task automatic t_unknown();
        pulse_attn();
        serve(16'h0300, 4'd1, 4'd1, 1'b1, 16'h0110, 1'b0, "R8 bad cu code");
        pulse_attn();
        serve(16'h0150, 4'd2, 4'd1, 1'b1, 16'h0210, 1'b0, "R8 bad ru code");
    endtask

    task automatic t_soft_reset();
        pulse_evt(4'b0110);
        pulse_attn();
        serve(16'h0190, 4'd0, 4'd1, 1'b0, 16'h0010, 1'b0, "R4 soft reset");
    endtask

    task automatic t_pending();
        int seen = 0;
        @(negedge clk) attn_i = 1'b1;
        repeat (3) @(negedge clk);
        attn_i = 1'b0;
        serve(16'h0000, 4'd0, 4'd1, 1'b0, 16'h0010, 1'b0, "R7 pending 1");
        serve(16'h0000, 4'd0, 4'd1, 1'b0, 16'h0010, 1'b0, "R7 pending 2");
        fork
            begin
                @(negedge clk) attn_i = 1'b1;
                @(negedge clk) attn_i = 1'b0;
            end
            serve(16'h0000, 4'd0, 4'd1, 1'b0, 16'h0010, 1'b0, "R7 pending 3");
        join
        serve(16'h0000, 4'd0, 4'd1, 1'b0, 16'h0010, 1'b0, "R7 strobe during service");
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (cmd_fetch_o) seen++;
        end
        chk(seen == 0, "R7 no extra service", 16'(seen), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start();
        t_events();
        t_abort();
        t_unknown();
        t_soft_reset();
        t_pending();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule